// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KByte pages. It takes one request at a time, carrying the address, a write flag and a user flag. It reads the matching directory entry and then the matching table entry through a single-outstanding memory read port. At each level it checks the present, writable and user bits. It finishes with one response that carries either the physical address or a page fault and its cause. The faulting linear address stays in a register until the next fault replaces it.

The walk is a four-state machine. IDLE accepts a request (IDLE to DIR on `req_valid`). DIR reads the directory entry. When the read data arrives, DIR moves to TBL if the entry passes, or to DONE if it faults. TBL reads the table entry and always moves to DONE when the data arrives. DONE presents the response for one cycle and returns to IDLE. The directory base is a 20-bit frame number. Each entry is 32 bits wide, with present at bit 0, writable at bit 1 and user at bit 2, and the frame number in bits 31:12.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mem_req` and `fault_addr` are 0.
- R2: The first read address is {dir_base, vaddr[31:22], 2'b00}. The second read address is {directory entry[31:12], vaddr[21:12], 2'b00}.
- R3: A walk that passes every check responds with `rsp_fault`=0 and `rsp_paddr` = {table entry[31:12], vaddr[11:0]}, after exactly two reads.
- R4: If the directory entry has bit 0 clear, the walk faults after one read, with `rsp_cause[0]`=0.
- R5: If the table entry has bit 0 clear, the walk faults after two reads, with `rsp_cause[0]`=0.
- R6: A write faults with `rsp_cause[0]`=1 when bit 1 is clear at either level. This applies in supervisor mode too. If the directory entry denies the write, only one read is made.
- R7: A user access faults with `rsp_cause[0]`=1 when bit 2 is clear at either level. A supervisor access ignores bit 2.
- R8: On a fault, `rsp_cause[1]` equals the request's write flag, `rsp_cause[2]` equals its user flag, and `rsp_paddr` is 0.
- R9: On every fault, `fault_addr` takes the request's linear address. It keeps that value through later faultless walks and is visible from the response cycle on.
- R10: `req_ready` is 0 from acceptance through the response cycle, and `req_valid` is ignored during that time. Each accepted request gets exactly one `rsp_valid` pulse, one cycle long.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` arrives. The walk works for any read latency, including a response in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 20 | Frame number of the page directory |
| mem_req | output | 1 | Entry read request, held until data returns |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid, consumes the request |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_cause | output | 3 | {user, write, protection(1)/not-present(0)} |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| fault_addr | output | 32 | Linear address of the latest fault |

## Verification
Walks are driven through entries set up so that every path is taken. One set passes at both levels. Another stops at a missing directory entry and another at a missing table entry. Others are denied write or user access at the directory only, or at the table only. The read count and both read addresses separate a directory-level stop from a table-level stop. The cause bits separate missing pages from protection faults. Supervisor writes and reads to supervisor pages show that the user bit is ignored while the writable bit is still enforced. Memory latencies from zero to three cycles, back-to-back requests held on `req_valid`, and the lowest and highest linear addresses exercise the handshake and the offset and index boundaries.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic user;
        logic write;
        logic prot;
    } fcause_t;
endpackage

// File: rtl/pgw_entry_chk.sv
module pgw_entry_chk #(
    parameter int ENT_W = 32,
    parameter int P_BIT = 0,
    parameter int W_BIT = 1,
    parameter int U_BIT = 2
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             acc_wr,
    input  logic             acc_usr,
    input  logic             up_w,
    input  logic             up_u,
    output logic             fault,
    output logic             present,
    output logic             eff_w,
    output logic             eff_u
);
    always_comb begin
        present = entry[P_BIT];
        eff_w   = up_w & entry[W_BIT];
        eff_u   = up_u & entry[U_BIT];
        fault   = !present || (acc_wr && !eff_w) || (acc_usr && !eff_u);
    end
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int ENT_W  = 32
) (
    input  walk_st_e                  st,
    input  logic [ADDR_W-OFF_W-1:0]   dir_base,
    input  logic [ADDR_W-1:0]         va,
    input  logic [ADDR_W-OFF_W-1:0]   tbl_frame,
    output logic [ADDR_W-1:0]         mem_addr
);
    localparam int ENT_SH = $clog2(ENT_W / 8);
    localparam int IDX_W  = OFF_W - ENT_SH;
    localparam int HI_W   = ADDR_W - OFF_W - IDX_W;

    always_comb begin
        mem_addr = '0;
        unique case (st)
            ST_DIR:  mem_addr = {dir_base, va[ADDR_W-1 -: HI_W], {ENT_SH{1'b0}}};
            ST_TBL:  mem_addr = {tbl_frame, va[OFF_W +: IDX_W], {ENT_SH{1'b0}}};
            ST_IDLE: mem_addr = '0;
            ST_DONE: mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
    import pgw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     mem_rvalid,
    input  logic     lvl_fault,
    output walk_st_e st,
    output logic     req_ready,
    output logic     mem_req,
    output logic     rsp_valid,
    output logic     accept,
    output logic     rd_done
);
    walk_st_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req_valid)  st_nx = ST_DIR;
            ST_DIR:  if (mem_rvalid) st_nx = lvl_fault ? ST_DONE : ST_TBL;
            ST_TBL:  if (mem_rvalid) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_DIR:  mem_req   = 1'b1;
            ST_TBL:  mem_req   = 1'b1;
            ST_DONE: rsp_valid = 1'b1;
        endcase
        accept  = req_ready && req_valid;
        rd_done = mem_req && mem_rvalid;
    end

    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DONE |=> st == ST_IDLE);
    p_tbl_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TBL && mem_rvalid) |=> rsp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int ENT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic [ADDR_W-OFF_W-1:0] dir_base,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rvalid,
    input  logic [ENT_W-1:0]        mem_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [2:0]              rsp_cause,
    output logic [ADDR_W-1:0]       rsp_paddr,
    output logic [ADDR_W-1:0]       fault_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_st_e            st;
    logic                accept, rd_done;
    logic                lvl_fault, ent_present, eff_w, eff_u;
    logic                up_w, up_u;
    logic [ADDR_W-1:0]   va_q;
    logic                wr_q, usr_q;
    logic [FRAME_W-1:0]  tbl_frame_q;
    logic                pw_q, pu_q;
    fcause_t             cause_q;

    pgw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .mem_rvalid (mem_rvalid),
        .lvl_fault  (lvl_fault),
        .st         (st),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .rsp_valid  (rsp_valid),
        .accept     (accept),
        .rd_done    (rd_done)
    );

    pgw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_W(ENT_W)) u_addr (
        .st        (st),
        .dir_base  (dir_base),
        .va        (va_q),
        .tbl_frame (tbl_frame_q),
        .mem_addr  (mem_addr)
    );

    always_comb begin
        up_w = (st == ST_TBL) ? pw_q : 1'b1;
        up_u = (st == ST_TBL) ? pu_q : 1'b1;
    end

    pgw_entry_chk #(.ENT_W(ENT_W)) u_chk (
        .entry   (mem_rdata),
        .acc_wr  (wr_q),
        .acc_usr (usr_q),
        .up_w    (up_w),
        .up_u    (up_u),
        .fault   (lvl_fault),
        .present (ent_present),
        .eff_w   (eff_w),
        .eff_u   (eff_u)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            tbl_frame_q <= '0;
            pw_q        <= 1'b0;
            pu_q        <= 1'b0;
            rsp_fault   <= 1'b0;
            cause_q     <= '0;
            rsp_paddr   <= '0;
            fault_addr  <= '0;
        end else begin
            if (accept) begin
                va_q  <= req_vaddr;
                wr_q  <= req_write;
                usr_q <= req_user;
            end
            if (rd_done) begin
                if (lvl_fault) begin
                    rsp_fault  <= 1'b1;
                    cause_q    <= '{user: usr_q, write: wr_q, prot: ent_present};
                    rsp_paddr  <= '0;
                    fault_addr <= va_q;
                end else if (st == ST_DIR) begin
                    tbl_frame_q <= mem_rdata[ENT_W-1 -: FRAME_W];
                    pw_q        <= eff_w;
                    pu_q        <= eff_u;
                end else begin
                    rsp_fault <= 1'b0;
                    cause_q   <= '0;
                    rsp_paddr <= {mem_rdata[ENT_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
                end
            end
        end
    end

    assign rsp_cause = cause_q;

    p_hold_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> rsp_paddr == '0);
    p_fa_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (rsp_valid && rsp_fault));
    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    typedef struct {
        logic        fault;
        logic [2:0]  cause;
        logic [31:0] paddr;
        int          nrd;
        logic [31:0] a0;
        logic [31:0] a1;
        logic [31:0] va;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic [19:0] dir_base;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        rsp_valid, rsp_fault;
    logic [2:0]  rsp_cause;
    logic [31:0] rsp_paddr, fault_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 0;
    int wcnt = 0;
    int nrd = 0;
    logic [31:0] rd_log [2];
    logic [31:0] last_fva = '0;
    bit busy_ready = 1'b0;
    bit finished = 1'b0;
    exp_t exp_q[$];
    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .dir_base(dir_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
        .fault_addr(fault_addr)
    );

    task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exv);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mkva(int d, int t, int off);
        return {d[9:0], t[9:0], off[11:0]};
    endfunction

    function automatic exp_t model(logic [31:0] va, logic w, logic u, string tag);
        exp_t e;
        logic [31:0] de, te;
        e.va = va; e.tag = tag; e.fault = 1'b0; e.cause = 3'b0; e.paddr = '0;
        e.a0 = {dir_base, va[31:22], 2'b00};
        de = rd(e.a0);
        e.nrd = 1; e.a1 = '0;
        if (!de[0]) begin
            e.fault = 1'b1; e.cause = {u, w, 1'b0};
        end else if ((w && !de[1]) || (u && !de[2])) begin
            e.fault = 1'b1; e.cause = {u, w, 1'b1};
        end else begin
            e.a1 = {de[31:12], va[21:12], 2'b00};
            te = rd(e.a1);
            e.nrd = 2;
            if (!te[0]) begin
                e.fault = 1'b1; e.cause = {u, w, 1'b0};
            end else if ((w && !te[1]) || (u && !te[2])) begin
                e.fault = 1'b1; e.cause = {u, w, 1'b1};
            end else begin
                e.paddr = {te[31:12], va[11:0]};
            end
        end
        return e;
    endfunction

    task automatic send(logic [31:0] va, logic w, logic u, string tag);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = w;
        req_user  = u;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(model(va, w, u, tag));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // memory model: answers after lat waiting cycles
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wcnt = 0;
        end else if (rst_n && mem_req) begin
            if (wcnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(mem_addr);
                if (nrd < 2) rd_log[nrd] = mem_addr;
                nrd++;
            end else begin
                wcnt++;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req && req_ready) busy_ready = 1'b1;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_fault == e.fault, {e.tag, " fault flag"}, {31'b0, rsp_fault}, {31'b0, e.fault});
                check(rsp_paddr == e.paddr, {e.tag, " R3/R8 paddr"}, rsp_paddr, e.paddr);
                if (e.fault)
                    check(rsp_cause == e.cause, {e.tag, " R8 cause"}, {29'b0, rsp_cause}, {29'b0, e.cause});
                check(nrd == e.nrd, {e.tag, " read count"}, nrd, e.nrd);
                check(rd_log[0] == e.a0, {e.tag, " R2 dir addr"}, rd_log[0], e.a0);
                if (e.nrd == 2)
                    check(rd_log[1] == e.a1, {e.tag, " R2 tbl addr"}, rd_log[1], e.a1);
                if (e.fault) last_fva = e.va;
                check(fault_addr == last_fva, {e.tag, " R9 fault_addr"}, fault_addr, last_fva);
                check(!busy_ready, {e.tag, " R10 ready while busy"}, {31'b0, busy_ready}, 32'h0);
            end
            nrd = 0;
            busy_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        req_user = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        dir_base = 20'h00010;
        // directory at 0x10000
        mem[32'h0001_0000] = 32'h0002_0007;               // idx 0
        mem[32'h0001_0004] = 32'h0002_0007;               // idx 1
        mem[32'h0001_000C] = 32'h0002_1005;               // idx 3: read-only, user
        mem[32'h0001_0010] = 32'h0002_2003;               // idx 4: writable, supervisor
        mem[32'h0001_0FFC] = 32'h0002_3007;               // idx 0x3FF
        mem[32'h0002_0000] = 32'h0000_1007;
        mem[32'h0002_0014] = 32'h1234_5007;               // idx 5
        mem[32'h0002_001C] = 32'h0ABC_D005;               // idx 7 read-only
        mem[32'h0002_0020] = 32'h5555_5003;               // idx 8 supervisor
        mem[32'h0002_1014] = 32'h7777_7007;
        mem[32'h0002_2014] = 32'h6666_6007;
        mem[32'h0002_3FFC] = 32'hFEDC_B007;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 32'h0);
        check(fault_addr == 32'h0, "R1 fault_addr", fault_addr, 32'h0);

        lat = 0;
        send(mkva(1, 5, 12'h123), 1'b0, 1'b1, "R3 user read");
        drain();
        send(mkva(1, 5, 12'hABC), 1'b1, 1'b1, "R3 user write");
        drain();
        lat = 2;
        send(mkva(2, 5, 12'h010), 1'b1, 1'b1, "R4 dir missing");
        drain();
        send(mkva(1, 6, 12'h020), 1'b0, 1'b0, "R5 tbl missing");
        drain();
        send(mkva(1, 5, 12'h777), 1'b0, 1'b0, "R9 hold after fault");
        drain();
        send(mkva(1, 7, 12'h030), 1'b1, 1'b1, "R6 tbl read-only");
        drain();
        send(mkva(3, 5, 12'h040), 1'b1, 1'b0, "R6 dir read-only one read");
        drain();
        send(mkva(3, 5, 12'h044), 1'b0, 1'b1, "R3 read via ro dir");
        drain();
        send(mkva(1, 7, 12'h048), 1'b1, 1'b0, "R6 supervisor write ro");
        drain();
        send(mkva(4, 5, 12'h050), 1'b0, 1'b1, "R7 dir supervisor");
        drain();
        send(mkva(4, 5, 12'h054), 1'b1, 1'b0, "R7 supervisor ignores user bit");
        drain();
        send(mkva(1, 8, 12'h060), 1'b0, 1'b1, "R7 tbl supervisor");
        drain();
        send(mkva(1, 8, 12'h064), 1'b1, 1'b0, "R7 supervisor write ok");
        drain();
        lat = 3;
        send(32'h0000_0000, 1'b0, 1'b0, "R11 low boundary");
        drain();
        send(32'hFFFF_FFFF, 1'b1, 1'b1, "R11 high boundary");
        drain();
        lat = 1;
        send(mkva(1, 5, 12'h001), 1'b0, 1'b1, "R10 back-to-back a");
        send(mkva(2, 0, 12'h002), 1'b0, 1'b1, "R10 back-to-back b");
        send(mkva(0, 0, 12'h003), 1'b1, 1'b0, "R10 back-to-back c");
        drain();
        lat = 0;
        send(mkva(1, 5, 12'hFFF), 1'b0, 1'b0, "R11 zero latency");
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all responses seen", exp_q.size(), 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule